// File: doc/BRIEF.md
# Time-Multiplexed Memory-Based FIR Filter

This block computes a finite impulse response over the most recent `TAPS` signed input samples using a single registered multiplier and a single accumulator. The sample history and the coefficient set each sit in a two-port register array. One port writes, and the other port reads for the tap sweep. A circular write pointer replaces a shifting delay line.

Each accepted sample starts a sweep. The sweep pairs coefficient address k with the sample k positions older than the newest one, for k counting up from 0. Each pair enters a two-stage multiply pipeline. After the last product has been summed, a dump pulse copies the running total to the output and clears the accumulator in that same cycle. The output is then marked valid for one cycle.

The sample that is overwritten in the history is presented on a cascade port. A second instance can take it as its own input, which extends the total filter length. Coefficients are loaded through an address/data/enable port, and only while the filter is idle. `TAPS` must be a power of two of at least 2.

Top module: `fir_tdm`

## Requirements
- R1: While reset is asserted and on release, `in_ready` is 1, and `out_valid`, `casc_valid` and `out_data` are 0.
- R2: `in_ready` is high only while the filter is idle. After the rising edge that accepts a sample, `in_ready` stays low for exactly TAPS+4 cycles. A sample offered while `in_ready` is low is not taken.
- R3: `out_valid` is a one-cycle pulse that is visible after the (TAPS+4)th rising edge following the accepting edge. It is high in the same cycle in which `in_ready` returns high.
- R4: With `out_valid` high, `out_data` equals the sum over k = 0..TAPS-1 of c[k]·x[n-k]. Here c[k] is the two's-complement coefficient stored at `cf_addr` = k, and x[n] is the newest accepted two's-complement sample.
- R5: `out_data` keeps its value in every cycle in which `out_valid` is low.
- R6: When `cf_we` is high at a rising edge while `in_ready` is high, `cf_data` is stored at `cf_addr`. When `cf_we` is high while `in_ready` is low, the write is ignored.
- R7: One rising edge after a sample is accepted, `casc_valid` is high for one cycle. At that time `casc_sample` carries the sample that was accepted TAPS acceptances earlier.
- R8: The output width SMP_W+COEF_W+log2(TAPS) holds the exact sum even when every sample and every coefficient is at its most negative or most positive value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A new sample is offered |
| in_ready | output | 1 | The filter is idle and takes a sample |
| in_sample | input | SMP_W | Signed input sample |
| cf_we | input | 1 | Coefficient write enable |
| cf_addr | input | log2(TAPS) | Coefficient address (tap index) |
| cf_data | input | COEF_W | Signed coefficient value |
| out_valid | output | 1 | One-cycle strobe for a finished sum |
| out_data | output | SMP_W+COEF_W+log2(TAPS) | Signed filter result |
| casc_valid | output | 1 | Strobe for the evicted sample |
| casc_sample | output | SMP_W | Sample that left the history |

## Verification
The hardest situations to reach are a coefficient write, or a held `in_valid`, arriving in the middle of a sweep. From the ports these can only be seen through later sums. The bench therefore holds `in_valid` high through the whole busy window and drives a coefficient write in the second sweep cycle. It then runs impulse and step sequences, whose outputs reveal each stored coefficient individually. The cascade value can only be predicted once the history has been completely overwritten, so a full flush of zero samples comes before any checked eviction.

// File: rtl/fir_tdm_pkg.sv
package fir_tdm_pkg;
  // sequencer phases
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SWEEP,
    ST_DRAIN,
    ST_DUMP
  } seq_st_e;

  // registers between the last tap address and the accumulator update:
  // memory read register, operand register, product register
  localparam int MAC_DRAIN = 3;
endpackage

// File: rtl/fir_tdm_ram.sv
module fir_tdm_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 256
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [W-1:0]             wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [W-1:0]             rd_data
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_q;

  // write port and registered read port; a read of the written
  // address returns the value from before the write
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
    rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/fir_tdm_seq.sv
module fir_tdm_seq
  import fir_tdm_pkg::*;
#(
  parameter int TAPS = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    cf_we,
  output logic                    in_ready,
  output logic                    accept,
  output logic                    cf_wr_ok,
  output logic [$clog2(TAPS)-1:0] smp_waddr,
  output logic [$clog2(TAPS)-1:0] smp_raddr,
  output logic [$clog2(TAPS)-1:0] cf_raddr,
  output logic                    tap_act,
  output logic                    restart
);
  localparam int AW = $clog2(TAPS);

  seq_st_e       st_q, st_d;
  logic [AW-1:0] tap_q, tap_d;
  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    drn_q, drn_d;

  assign in_ready  = (st_q == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign cf_wr_ok  = cf_we && in_ready;
  assign tap_act   = (st_q == ST_SWEEP);
  assign restart   = (st_q == ST_DUMP);
  assign smp_waddr = wptr_q;
  // sweep: newest to oldest; idle: the slot about to be overwritten
  assign smp_raddr = tap_act ? (base_q - tap_q) : wptr_q;
  assign cf_raddr  = tap_q;

  always_comb begin
    st_d   = st_q;
    tap_d  = tap_q;
    wptr_d = wptr_q;
    base_d = base_q;
    drn_d  = drn_q;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_SWEEP;
          base_d = wptr_q;
          wptr_d = wptr_q + AW'(1);
          tap_d  = '0;
        end
      end
      ST_SWEEP: begin
        tap_d = tap_q + AW'(1);
        if (tap_q == AW'(TAPS - 1)) begin
          st_d  = ST_DRAIN;
          drn_d = '0;
        end
      end
      ST_DRAIN: begin
        drn_d = drn_q + 2'd1;
        if (drn_q == 2'(MAC_DRAIN - 1)) begin
          st_d = ST_DUMP;
        end
      end
      ST_DUMP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tap_q  <= '0;
      wptr_q <= '0;
      base_q <= '0;
      drn_q  <= '0;
    end else begin
      st_q   <= st_d;
      tap_q  <= tap_d;
      wptr_q <= wptr_d;
      base_q <= base_d;
      drn_q  <= drn_d;
    end
  end
endmodule

// File: rtl/fir_tdm_mac.sv
module fir_tdm_mac #(
  parameter int CW = 16,
  parameter int SW = 16,
  parameter int GW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      op_vld,
  input  logic signed [CW-1:0]      coef,
  input  logic signed [SW-1:0]      smp,
  input  logic                      restart,
  output logic signed [CW+SW+GW-1:0] sum_q,
  output logic                      sum_vld
);
  localparam int PW   = CW + SW;
  localparam int ACCW = PW + GW;

  logic signed [CW-1:0]   a_q, a_d;
  logic signed [SW-1:0]   b_q, b_d;
  logic signed [PW-1:0]   p_q, p_d;
  logic signed [ACCW-1:0] acc_q, acc_d;
  logic signed [ACCW-1:0] out_q, out_d;
  logic                   vld_q;

  always_comb begin
    // idle slots feed zero so the accumulator can add every cycle
    a_d   = op_vld ? coef : '0;
    b_d   = op_vld ? smp  : '0;
    p_d   = PW'(a_q) * PW'(b_q);
    // dump: copy the total out, clear, and drop the product of this cycle
    acc_d = restart ? '0 : (acc_q + ACCW'(p_q));
    out_d = restart ? acc_q : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      p_q   <= '0;
      acc_q <= '0;
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      p_q   <= p_d;
      acc_q <= acc_d;
      out_q <= out_d;
      vld_q <= restart;
    end
  end

  assign sum_q   = out_q;
  assign sum_vld = vld_q;
endmodule

// File: rtl/fir_tdm.sv
module fir_tdm #(
  parameter int TAPS   = 256,
  parameter int SMP_W  = 16,
  parameter int COEF_W = 16
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     in_valid,
  output logic                                     in_ready,
  input  logic [SMP_W-1:0]                         in_sample,
  input  logic                                     cf_we,
  input  logic [$clog2(TAPS)-1:0]                  cf_addr,
  input  logic [COEF_W-1:0]                        cf_data,
  output logic                                     out_valid,
  output logic signed [SMP_W+COEF_W+$clog2(TAPS)-1:0] out_data,
  output logic                                     casc_valid,
  output logic [SMP_W-1:0]                         casc_sample
);
  localparam int AW    = $clog2(TAPS);
  localparam int ACC_W = SMP_W + COEF_W + AW;

  logic              accept, cf_wr_ok, tap_act, restart;
  logic [AW-1:0]     smp_waddr, smp_raddr, cf_raddr;
  logic [SMP_W-1:0]  smp_rd;
  logic [COEF_W-1:0] cf_rd;
  logic              tv_q, cv_q;

  fir_tdm_seq #(.TAPS(TAPS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cf_we     (cf_we),
    .in_ready  (in_ready),
    .accept    (accept),
    .cf_wr_ok  (cf_wr_ok),
    .smp_waddr (smp_waddr),
    .smp_raddr (smp_raddr),
    .cf_raddr  (cf_raddr),
    .tap_act   (tap_act),
    .restart   (restart)
  );

  fir_tdm_ram #(.W(SMP_W), .DEPTH(TAPS)) u_smp_ram (
    .clk     (clk),
    .wr_en   (accept),
    .wr_addr (smp_waddr),
    .wr_data (in_sample),
    .rd_addr (smp_raddr),
    .rd_data (smp_rd)
  );

  fir_tdm_ram #(.W(COEF_W), .DEPTH(TAPS)) u_cf_ram (
    .clk     (clk),
    .wr_en   (cf_wr_ok),
    .wr_addr (cf_addr),
    .wr_data (cf_data),
    .rd_addr (cf_raddr),
    .rd_data (cf_rd)
  );

  // align the tap flag and the eviction flag with the memory read register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv_q <= 1'b0;
      cv_q <= 1'b0;
    end else begin
      tv_q <= tap_act;
      cv_q <= accept;
    end
  end

  fir_tdm_mac #(.CW(COEF_W), .SW(SMP_W), .GW(AW)) u_mac (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_vld  (tv_q),
    .coef    (cf_rd),
    .smp     (smp_rd),
    .restart (restart),
    .sum_q   (out_data),
    .sum_vld (out_valid)
  );

  assign casc_valid  = cv_q;
  assign casc_sample = smp_rd;
endmodule

// File: rtl/fir_tdm_chk.sv
module fir_tdm_chk #(
  parameter int DW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          casc_valid
);
  AST_RDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);                    // R2
  AST_OUT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);                              // R3
  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);                                // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));                      // R5
  AST_CASC_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> casc_valid);                   // R7
  AST_CASC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    casc_valid |=> !casc_valid);                            // R7
  AST_CASC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    casc_valid |-> !in_ready);                              // R7
endmodule

bind fir_tdm fir_tdm_chk #(.DW(SMP_W + COEF_W + $clog2(TAPS))) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .casc_valid (casc_valid)
);

// File: tb/test_fir_tdm.sv
`timescale 1ns/1ps
module test_fir_tdm;
  localparam int TAPS  = 8;
  localparam int SW    = 6;
  localparam int CW    = 5;
  localparam int AW    = 3;
  localparam int ACC_W = SW + CW + AW;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [SW-1:0]     in_sample;
  logic              cf_we;
  logic [AW-1:0]     cf_addr;
  logic [CW-1:0]     cf_data;
  logic              out_valid;
  logic signed [ACC_W-1:0] out_data;
  logic              casc_valid;
  logic [SW-1:0]     casc_sample;

  int total = 0;
  int bad   = 0;
  int cf [TAPS];
  int hist [512];
  int cnt = 0;
  longint last_out = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  fir_tdm #(.TAPS(TAPS), .SMP_W(SW), .COEF_W(CW)) i_fir_tdm (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_sample (in_sample), .cf_we (cf_we), .cf_addr (cf_addr),
    .cf_data (cf_data), .out_valid (out_valid), .out_data (out_data),
    .casc_valid (casc_valid), .casc_sample (casc_sample)
  );

  function automatic int sx(int v, int w);
    int m = v & ((1 << w) - 1);
    return (m >= (1 << (w - 1))) ? m - (1 << w) : m;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_coef(int a, int v);
    @(negedge clk);
    cf_we   = 1'b1;
    cf_addr = a[AW-1:0];
    cf_data = v[CW-1:0];
    if (in_ready) cf[a] = sx(v, CW);  // R6: stored only while idle
    @(negedge clk);
    cf_we = 1'b0;
  endtask

  task automatic push(int v, bit hold, bit busy_wr, string req);
    longint exp;
    longint got;
    bit rdy_ok;
    bit vld_ok;
    @(negedge clk);
    if (cnt > 0) chk(out_data == last_out, "R5", out_data, last_out);
    in_valid  = 1'b1;
    in_sample = v[SW-1:0];
    while (!in_ready) @(negedge clk);
    hist[cnt] = sx(v, SW);
    cnt++;
    exp = 0;
    for (int k = 0; k < TAPS; k++) begin
      if (cnt - 1 - k >= 0) exp += longint'(cf[k]) * longint'(hist[cnt - 1 - k]);
    end
    rdy_ok = 1'b1;
    vld_ok = 1'b1;
    got    = 0;
    for (int m = 1; m <= TAPS + 5; m++) begin
      @(negedge clk);
      if (m == 1) begin
        if (!hold) in_valid = 1'b0;
        if (cnt > TAPS)
          chk(casc_valid && (sx(int'(casc_sample), SW) == hist[cnt - 1 - TAPS]),
              "R7", sx(int'(casc_sample), SW), hist[cnt - 1 - TAPS]);
        else
          chk(casc_valid == 1'b1, "R7", casc_valid, 1);
      end
      if (m == 2 && busy_wr) begin
        cf_we   = 1'b1;
        cf_addr = AW'(cnt % TAPS);
        cf_data = CW'(11);
      end
      if (m == 3 && busy_wr) cf_we = 1'b0;
      if (m == TAPS + 4) in_valid = 1'b0;
      if (in_ready  != (m == TAPS + 5)) rdy_ok = 1'b0;
      if (out_valid != (m == TAPS + 5)) vld_ok = 1'b0;
      if (m == TAPS + 5) got = out_data;
    end
    chk(rdy_ok, "R2", rdy_ok, 1);
    chk(vld_ok, "R3", vld_ok, 1);
    if (cnt >= TAPS) chk(got == exp, req, got, exp);
    last_out = got;
  endtask

  function automatic int rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return int'(seed & 32'h3F);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sample = '0;
    cf_we     = 1'b0;
    cf_addr   = '0;
    cf_data   = '0;
    for (int k = 0; k < TAPS; k++) cf[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle state after reset
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(casc_valid == 1'b0, "R1", casc_valid, 0);
    chk(out_data == 0, "R1", out_data, 0);

    // R6: legal coefficient load while idle
    for (int k = 0; k < TAPS; k++) wr_coef(k, 3 * k - 10);
    // flush the history with zeros
    for (int i = 0; i < TAPS; i++) push(0, 1'b0, 1'b0, "R4");
    // impulse: each output exposes one coefficient (R4, R6)
    push(1, 1'b0, 1'b0, "R6");
    for (int i = 0; i < TAPS; i++) push(0, 1'b0, 1'b0, "R6");
    // step
    for (int i = 0; i < 10; i++) push(5, 1'b0, 1'b0, "R4");
    // R6 ignored writes and R2 held in_valid during busy, then impulse
    push(-3, 1'b1, 1'b1, "R6");
    for (int i = 0; i < TAPS; i++) push(0, 1'b1, 1'b1, "R6");
    // random stream
    for (int i = 0; i < 60; i++) push(rnd(), 1'b0, 1'b0, "R4");
    // R8: full-scale sums
    for (int k = 0; k < TAPS; k++) wr_coef(k, -16);
    for (int i = 0; i < TAPS + 1; i++) push(-32, 1'b0, 1'b0, "R8");
    for (int i = 0; i < TAPS + 1; i++) push(31, 1'b0, 1'b0, "R8");
    for (int k = 0; k < TAPS; k++) wr_coef(k, 15);
    for (int i = 0; i < TAPS + 1; i++) push(-32, 1'b0, 1'b0, "R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule